// File: doc/BRIEF.md
# Sound Board Mailbox and Interrupt Timer

This block links a main processor with the processor on a sound/I/O board. The main processor posts command bytes into four mailbox latches through its I/O port space. The sound processor reads those latches through a window in its memory map. In the other direction, the sound processor writes a single status byte, which the main processor reads back through its port space.

A divider counts an external tick strobe and raises a periodic interrupt to the sound processor once every eighteen ticks. The sound processor acknowledges the interrupt by reading anywhere in a dedicated window. That read returns all ones and also restarts the count. A further window gives the sound processor the board's DIP switch byte. The block also drives the sound processor's reset hold. All read data paths are combinational and all state changes on the rising clock edge.

Top module: `snd_mailbox_hub`

## Requirements
- R1: A main-side write with `host_wr` high to port 0x1C, 0x1D, 0x1E or 0x1F stores `host_wdata` into mailbox latch number port[1:0]. A write to any other port leaves all four latches unchanged.
- R2: A sound-side read with `snd_rd` high and address bits [15:12] equal to 0x9 returns latch number addr[1:0] on `snd_rdata` in the same cycle. Address bits [11:2] play no part in this decode.
- R3: A sound-side write with `snd_wr` high and address bits [15:12] equal to 0xC stores `snd_wdata` as the status byte. Sound-side writes at any other address leave the status byte unchanged.
- R4: A main-side read returns the status byte on `host_rdata` when the port with bits 4 and 3 cleared equals 0x07. These are ports 0x07, 0x0F, 0x17 and 0x1F.
- R5: A main-side read of any other port returns 0xFF.
- R6: Each clock cycle with `tick` high advances the divider by one. The cycle after the 18th counted tick, `snd_irq` is high and the count has restarted from zero. Cycles without `tick` do not advance the count.
- R7: A sound-side read with address bits [15:12] equal to 0xE returns 0xFF. From the next cycle on, `snd_irq` is low and the count is zero. A tick in the same cycle as this read is not counted.
- R8: A sound-side read with address bits [15:12] equal to 0xF returns `dip_sw`.
- R9: A sound-side read in any other address range returns 0x00.
- R10: While `rst` is high, `snd_hold` is high. Reset clears all four latches, the status byte, the divider count and `snd_irq`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high board reset |
| host_port | input | 8 | Main-side I/O port address |
| host_wr | input | 1 | Main-side port write strobe |
| host_rd | input | 1 | Main-side port read strobe |
| host_wdata | input | 8 | Main-side write data |
| host_rdata | output | 8 | Main-side read data |
| snd_addr | input | 16 | Sound-side memory address |
| snd_wr | input | 1 | Sound-side memory write strobe |
| snd_rd | input | 1 | Sound-side memory read strobe |
| snd_wdata | input | 8 | Sound-side write data |
| snd_rdata | output | 8 | Sound-side read data |
| tick | input | 1 | Divider advance strobe |
| dip_sw | input | 8 | DIP switch byte |
| snd_irq | output | 1 | Interrupt to the sound processor |
| snd_hold | output | 1 | Reset hold for the sound processor |

## Verification
The bench reads mailbox addresses with scrambled middle bits. A decode that looked at those bits would return 0x00 instead of the latch. It writes to port 0x18, next to the mailbox ports, and to the 0xD window, next to the status window; a loose decode would corrupt a latch or the status byte. It counts ticks exactly to 17 and then 18, which exposes an off-by-one divider as an early or late interrupt. It fires an acknowledge and a tick in the same cycle. If the tick were counted, the next interrupt would come one tick early.

// File: rtl/snd_mbox_pkg.sv
package snd_mbox_pkg;

    localparam int DATA_W    = 8;
    localparam int ADDR_W    = 16;
    localparam int PORT_W    = 8;
    localparam int NUM_BOX   = 4;
    localparam int BOX_SEL_W = $clog2(NUM_BOX);

    // sound-side windows are selected by the top address nibble
    localparam logic [ADDR_W-1:0] WIN_MASK   = 16'hF000;
    localparam logic [ADDR_W-1:0] WIN_MBOX   = 16'h9000;
    localparam logic [ADDR_W-1:0] WIN_STATUS = 16'hC000;
    localparam logic [ADDR_W-1:0] WIN_ACK    = 16'hE000;
    localparam logic [ADDR_W-1:0] WIN_DIP    = 16'hF000;

    // main-side ports
    localparam logic [PORT_W-1:0] MBOX_PORT_MASK  = 8'hFC;
    localparam logic [PORT_W-1:0] MBOX_PORT_BASE  = 8'h1C;
    localparam logic [PORT_W-1:0] STAT_PORT_MASK  = 8'hE7;
    localparam logic [PORT_W-1:0] STAT_PORT_VALUE = 8'h07;

    localparam logic [DATA_W-1:0] HOST_IDLE_BYTE = '1;
    localparam logic [DATA_W-1:0] SND_IDLE_BYTE  = '0;
    localparam logic [DATA_W-1:0] ACK_BYTE       = '1;

    typedef enum logic [2:0] {
        RG_NONE,
        RG_MBOX,
        RG_STATUS,
        RG_ACK,
        RG_DIP
    } snd_region_e;

    typedef struct packed {
        logic                 we;
        logic [BOX_SEL_W-1:0] sel;
        logic [DATA_W-1:0]    data;
    } box_wr_t;

    function automatic snd_region_e snd_region(input logic [ADDR_W-1:0] a);
        logic [ADDR_W-1:0] w;
        w = a & WIN_MASK;
        if (w == WIN_MBOX)        return RG_MBOX;
        else if (w == WIN_STATUS) return RG_STATUS;
        else if (w == WIN_ACK)    return RG_ACK;
        else if (w == WIN_DIP)    return RG_DIP;
        else                      return RG_NONE;
    endfunction

    function automatic logic is_mbox_port(input logic [PORT_W-1:0] p);
        return (p & MBOX_PORT_MASK) == MBOX_PORT_BASE;
    endfunction

    function automatic logic is_status_port(input logic [PORT_W-1:0] p);
        return (p & STAT_PORT_MASK) == STAT_PORT_VALUE;
    endfunction

endpackage

// File: rtl/snd_addr_decode.sv
module snd_addr_decode
    import snd_mbox_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    input  logic [PORT_W-1:0] port,
    output snd_region_e       region,
    output logic              port_is_box,
    output logic              port_is_stat
);
    always_comb begin
        region       = snd_region(addr);
        port_is_box  = is_mbox_port(port);
        port_is_stat = is_status_port(port);
    end
endmodule

// File: rtl/mbox_regs.sv
module mbox_regs
    import snd_mbox_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  box_wr_t              box_wr,
    input  logic                 stat_we,
    input  logic [DATA_W-1:0]    stat_wdata,
    input  logic [BOX_SEL_W-1:0] rd_sel,
    output logic [DATA_W-1:0]    box_rdata,
    output logic [DATA_W-1:0]    stat_q
);
    logic [DATA_W-1:0] box_q [NUM_BOX];

    for (genvar i = 0; i < NUM_BOX; i++) begin : g_box
        always_ff @(posedge clk) begin
            if (rst)
                box_q[i] <= '0;
            else if (box_wr.we && box_wr.sel == BOX_SEL_W'(i))
                box_q[i] <= box_wr.data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            stat_q <= '0;
        else if (stat_we)
            stat_q <= stat_wdata;
    end

    assign box_rdata = box_q[rd_sel];
endmodule

// File: rtl/irq_divider.sv
module irq_divider #(
    parameter int LIMIT = 18
) (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic ack,
    output logic irq
);
    localparam int CNT_W = $clog2(LIMIT + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(LIMIT - 1);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || ack) begin
            cnt_q <= '0;
            irq   <= 1'b0;
        end else if (tick) begin
            if (cnt_q == LAST) begin
                cnt_q <= '0;
                irq   <= 1'b1;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end
endmodule

// File: rtl/snd_mailbox_hub.sv
module snd_mailbox_hub
    import snd_mbox_pkg::*;
#(
    parameter int DIV_LIMIT = 18
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [PORT_W-1:0] host_port,
    input  logic              host_wr,
    input  logic              host_rd,
    input  logic [DATA_W-1:0] host_wdata,
    output logic [DATA_W-1:0] host_rdata,
    input  logic [ADDR_W-1:0] snd_addr,
    input  logic              snd_wr,
    input  logic              snd_rd,
    input  logic [DATA_W-1:0] snd_wdata,
    output logic [DATA_W-1:0] snd_rdata,
    input  logic              tick,
    input  logic [DATA_W-1:0] dip_sw,
    output logic              snd_irq,
    output logic              snd_hold
);
    snd_region_e       region;
    logic              port_is_box;
    logic              port_is_stat;
    box_wr_t           box_wr;
    logic [DATA_W-1:0] box_rdata;
    logic [DATA_W-1:0] stat_q;
    logic              ack_rd;

    snd_addr_decode u_dec (
        .addr         (snd_addr),
        .port         (host_port),
        .region       (region),
        .port_is_box  (port_is_box),
        .port_is_stat (port_is_stat)
    );

    always_comb begin
        box_wr.we   = host_wr && port_is_box;
        box_wr.sel  = host_port[BOX_SEL_W-1:0];
        box_wr.data = host_wdata;
    end

    mbox_regs u_regs (
        .clk        (clk),
        .rst        (rst),
        .box_wr     (box_wr),
        .stat_we    (snd_wr && region == RG_STATUS),
        .stat_wdata (snd_wdata),
        .rd_sel     (snd_addr[BOX_SEL_W-1:0]),
        .box_rdata  (box_rdata),
        .stat_q     (stat_q)
    );

    assign ack_rd = snd_rd && region == RG_ACK;

    irq_divider #(.LIMIT(DIV_LIMIT)) u_div (
        .clk  (clk),
        .rst  (rst),
        .tick (tick),
        .ack  (ack_rd),
        .irq  (snd_irq)
    );

    always_comb begin
        unique case (region)
            RG_MBOX: snd_rdata = box_rdata;
            RG_ACK:  snd_rdata = ACK_BYTE;
            RG_DIP:  snd_rdata = dip_sw;
            default: snd_rdata = SND_IDLE_BYTE;
        endcase
    end

    assign host_rdata = port_is_stat ? stat_q : HOST_IDLE_BYTE;
    assign snd_hold   = rst;
endmodule

// File: rtl/snd_mailbox_hub_chk.sv
module snd_mailbox_hub_chk
    import snd_mbox_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic [PORT_W-1:0] host_port,
    input logic              host_rd,
    input logic [DATA_W-1:0] host_rdata,
    input logic [ADDR_W-1:0] snd_addr,
    input logic              snd_rd,
    input logic [DATA_W-1:0] snd_rdata,
    input logic              tick,
    input logic [DATA_W-1:0] dip_sw,
    input logic              snd_irq
);
    AST_ACK_CLEARS_IRQ: assert property (@(posedge clk) disable iff (rst)
        (snd_rd && snd_addr[15:12] == 4'hE) |=> !snd_irq); // R7

    AST_ACK_READS_ONES: assert property (@(posedge clk) disable iff (rst)
        (snd_rd && snd_addr[15:12] == 4'hE) |-> snd_rdata == 8'hFF); // R7

    AST_IRQ_NEEDS_TICK: assert property (@(posedge clk) disable iff (rst)
        $rose(snd_irq) |-> $past(tick)); // R6

    AST_DIP_PASSTHRU: assert property (@(posedge clk) disable iff (rst)
        (snd_rd && snd_addr[15:12] == 4'hF) |-> snd_rdata == dip_sw); // R8

    AST_HOST_IDLE_ONES: assert property (@(posedge clk) disable iff (rst)
        (host_rd && (host_port & 8'hE7) != 8'h07) |-> host_rdata == 8'hFF); // R5

    AST_SND_IDLE_ZERO: assert property (@(posedge clk) disable iff (rst)
        (snd_rd && snd_addr[15:12] != 4'h9 && snd_addr[15:12] < 4'hE) |-> snd_rdata == 8'h00); // R9
endmodule

bind snd_mailbox_hub snd_mailbox_hub_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .host_port  (host_port),
    .host_rd    (host_rd),
    .host_rdata (host_rdata),
    .snd_addr   (snd_addr),
    .snd_rd     (snd_rd),
    .snd_rdata  (snd_rdata),
    .tick       (tick),
    .dip_sw     (dip_sw),
    .snd_irq    (snd_irq)
);

// File: tb/sim_snd_mailbox_hub.sv
module sim_snd_mailbox_hub;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] host_port = '0;
    logic       host_wr = 1'b0;
    logic       host_rd = 1'b0;
    logic [7:0] host_wdata = '0;
    logic [7:0] host_rdata;
    logic [15:0] snd_addr = '0;
    logic       snd_wr = 1'b0;
    logic       snd_rd = 1'b0;
    logic [7:0] snd_wdata = '0;
    logic [7:0] snd_rdata;
    logic       tick = 1'b0;
    logic [7:0] dip_sw = 8'hA5;
    logic       snd_irq;
    logic       snd_hold;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    snd_mailbox_hub u0 (
        .clk(clk), .rst(rst),
        .host_port(host_port), .host_wr(host_wr), .host_rd(host_rd),
        .host_wdata(host_wdata), .host_rdata(host_rdata),
        .snd_addr(snd_addr), .snd_wr(snd_wr), .snd_rd(snd_rd),
        .snd_wdata(snd_wdata), .snd_rdata(snd_rdata),
        .tick(tick), .dip_sw(dip_sw), .snd_irq(snd_irq), .snd_hold(snd_hold)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic host_write(input logic [7:0] p, input logic [7:0] d);
        @(negedge clk);
        host_port = p; host_wdata = d; host_wr = 1'b1;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic snd_write(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        snd_addr = a; snd_wdata = d; snd_wr = 1'b1;
        @(negedge clk);
        snd_wr = 1'b0;
    endtask

    // combinational peek without a read strobe edge effect
    task automatic host_peek(input logic [7:0] p, output logic [7:0] d);
        host_port = p; host_rd = 1'b1;
        #1 d = host_rdata;
        host_rd = 1'b0;
    endtask

    task automatic snd_peek(input logic [15:0] a, output logic [7:0] d);
        snd_addr = a;
        #1 d = snd_rdata;
    endtask

    task automatic pulse_ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); tick = 1'b1;
            @(negedge clk); tick = 1'b0;
        end
    endtask

    task automatic do_ack();
        @(negedge clk);
        snd_addr = 16'hE123; snd_rd = 1'b1;
        #1 check("R7 ack read data", snd_rdata, 8'hFF);
        @(negedge clk);
        snd_rd = 1'b0; snd_addr = 16'h0000;
    endtask

    task automatic t_reset_state();
        logic [7:0] d;
        @(negedge clk);
        check("R10 hold during reset", {7'd0, snd_hold}, 8'h01);
        check("R10 irq low in reset", {7'd0, snd_irq}, 8'h00);
        rst = 1'b0;
        @(negedge clk);
        check("R10 hold released", {7'd0, snd_hold}, 8'h00);
        for (int i = 0; i < 4; i++) begin
            snd_peek(16'h9000 + 16'(i), d);
            check("R10 latch clear after reset", d, 8'h00);
        end
        host_peek(8'h07, d);
        check("R10 status clear after reset", d, 8'h00);
    endtask

    task automatic t_mailbox();
        logic [7:0] d;
        host_write(8'h1C, 8'h11);
        host_write(8'h1D, 8'h22);
        host_write(8'h1E, 8'h33);
        host_write(8'h1F, 8'h44);
        host_write(8'h18, 8'hEE);   // neighbour port: no effect
        host_write(8'h3C, 8'hDD);   // upper bit set: no effect
        @(negedge clk);
        snd_peek(16'h9000, d); check("R1 latch0", d, 8'h11);
        snd_peek(16'h9001, d); check("R1 latch1", d, 8'h22);
        snd_peek(16'h9002, d); check("R1 latch2", d, 8'h33);
        snd_peek(16'h9003, d); check("R1 latch3", d, 8'h44);
        snd_peek(16'h9FFD, d); check("R2 alias FFD to latch1", d, 8'h22);
        snd_peek(16'h9A56, d); check("R2 alias A56 to latch2", d, 8'h33);
        snd_peek(16'h9004, d); check("R2 alias 004 to latch0", d, 8'h11);
    endtask

    task automatic t_status();
        logic [7:0] d;
        snd_write(16'hC3A7, 8'h5A);
        snd_write(16'hD000, 8'h99);  // outside status window
        snd_write(16'hB000, 8'h77);
        @(negedge clk);
        host_peek(8'h07, d); check("R4 status port 07", d, 8'h5A);
        host_peek(8'h0F, d); check("R4 status port 0F", d, 8'h5A);
        host_peek(8'h17, d); check("R4 status port 17", d, 8'h5A);
        host_peek(8'h1F, d); check("R4 status port 1F", d, 8'h5A);
        snd_write(16'hCFFF, 8'hC3);
        @(negedge clk);
        host_peek(8'h07, d); check("R3 status rewrite", d, 8'hC3);
    endtask

    task automatic t_host_unmapped();
        logic [7:0] d;
        host_peek(8'h06, d); check("R5 port 06", d, 8'hFF);
        host_peek(8'h27, d); check("R5 port 27", d, 8'hFF);
        host_peek(8'h1C, d); check("R5 port 1C", d, 8'hFF);
    endtask

    task automatic t_sound_reads();
        logic [7:0] d;
        dip_sw = 8'h3C;
        snd_peek(16'hF000, d); check("R8 dip F000", d, 8'h3C);
        dip_sw = 8'hC5;
        snd_peek(16'hFFFF, d); check("R8 dip FFFF", d, 8'hC5);
        snd_peek(16'h0000, d); check("R9 unmapped 0000", d, 8'h00);
        snd_peek(16'hA001, d); check("R9 unmapped A001", d, 8'h00);
        snd_peek(16'hC000, d); check("R9 status window read", d, 8'h00);
        snd_peek(16'h8FFF, d); check("R9 unmapped 8FFF", d, 8'h00);
    endtask

    task automatic t_divider();
        do_ack();
        pulse_ticks(17);
        check("R6 no irq after 17 ticks", {7'd0, snd_irq}, 8'h00);
        repeat (5) @(negedge clk);
        check("R6 idle cycles not counted", {7'd0, snd_irq}, 8'h00);
        pulse_ticks(1);
        check("R6 irq after 18th tick", {7'd0, snd_irq}, 8'h01);
        do_ack();
        check("R7 irq cleared by ack", {7'd0, snd_irq}, 8'h00);
        pulse_ticks(17);
        check("R7 count restarted by ack", {7'd0, snd_irq}, 8'h00);
        // ack collides with tick: the tick is dropped
        @(negedge clk);
        snd_addr = 16'hE000; snd_rd = 1'b1; tick = 1'b1;
        @(negedge clk);
        snd_rd = 1'b0; tick = 1'b0; snd_addr = 16'h0000;
        check("R7 no irq on ack+tick", {7'd0, snd_irq}, 8'h00);
        pulse_ticks(17);
        check("R7 tick with ack not counted", {7'd0, snd_irq}, 8'h00);
        pulse_ticks(1);
        check("R6 irq after full period", {7'd0, snd_irq}, 8'h01);
    endtask

    task automatic t_reset_clear();
        logic [7:0] d;
        @(negedge clk);
        rst = 1'b1;
        #1 check("R10 hold follows reset", {7'd0, snd_hold}, 8'h01);
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        check("R10 irq cleared", {7'd0, snd_irq}, 8'h00);
        snd_peek(16'h9003, d); check("R10 latch3 cleared", d, 8'h00);
        snd_peek(16'h9000, d); check("R10 latch0 cleared", d, 8'h00);
        host_peek(8'h07, d); check("R10 status cleared", d, 8'h00);
        pulse_ticks(17);
        check("R10 count cleared", {7'd0, snd_irq}, 8'h00);
        pulse_ticks(1);
        check("R10 period after reset", {7'd0, snd_irq}, 8'h01);
    endtask

    initial begin
        t_reset_state();
        t_mailbox();
        t_status();
        t_host_unmapped();
        t_sound_reads();
        t_divider();
        host_write(8'h1F, 8'h80);
        snd_write(16'hC000, 8'h81);
        t_reset_clear();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                n_checks++;
                n_errors++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end
endmodule